// File: doc/BRIEF.md
# Voltage Regulator Startup Sequencer

This block controls the power-up order of a multiphase core regulator. When both the enable input and the supply-good input are high, it runs a programmable delay. It then holds an eight-cycle window in which the PWM outputs stay blanked, so that external logic can count the populated phases. After that window it raises a digital reference code one step at a time up to a fixed boot level. The reference is an unsigned count of 6.25 mV units.

The reference then stays at the boot level for a second programmable interval. At the end of that interval the block captures the processor's voltage-identification code. It ramps up or down to that target. A fixed masking interval follows, then a final blanking delay, and then power-good goes high. The ramp pace comes from a 3-bit slew code. The delay interval and the slew code are both captured when the sequence leaves idle. If either qualifying input drops, the block returns to idle on the next clock edge.

Top module: `vrseq_top`

## Requirements
- R1: The sequence starts only on a clock edge that sees both `en_i` and `uv_ok_i` high. While either one is low, `ref_code_o` is 0, `pwm_blank_o` is 1, and `pdet_win_o` and `pgood_o` are 0.
- R2: The delay interval is (D+1) x CLK_KHZ/4 cycles, where D is the delay code; code 7 gives 2 ms. `pdet_win_o` first reads high after the clock edge that comes that many edges after the start edge.
- R3: `pdet_win_o` stays high for exactly 8 cycles. During those cycles `pwm_blank_o` is 1 and `ref_code_o` is 0. `pwm_blank_o` goes to 0 on the edge that ends the window.
- R4: After the window, `ref_code_o` rises by one code per step from 0 to BOOT_CODE (default 176, which is 1.1 V). It reaches BOOT_CODE 176 x S edges after the window ends, where S is the step period.
- R5: The reference holds at BOOT_CODE for one more cycle plus one delay interval. `vid_i` is captured only on the last edge of that hold. Values on `vid_i` before or after that edge have no effect.
- R6: The second ramp moves `ref_code_o` one code per step, up or down, and stops exactly at the captured code. After the last step, one further cycle passes before the ramp state ends.
- R7: The step period is S = max(1, floor(CLK_KHZ x 6.25 / rate)) cycles. The rate in mV/ms comes from the slew code: 0 and 1 give 300, 2 gives 500, 3 gives 700, 4 gives 900, 5 gives 1100, 6 gives 1300 and 7 gives 1500.
- R8: After the second ramp ends, a masking interval of CLK_KHZ/20 cycles (50 us) runs, then one delay interval. `pgood_o` then goes high and stays high while both qualifying inputs stay high. `pgood_o` therefore first reads high after edge 3T + 10 + 176S + |V-176|S + M after the start edge, where T is the delay interval, V is the captured code and M is the masking interval.
- R9: If `en_i` or `uv_ok_i` is low at a clock edge, then after that edge `ref_code_o` is 0, `pgood_o` is 0, `pdet_win_o` is 0 and `pwm_blank_o` is 1.
- R10: The delay code and the slew code are captured on the start edge. Changes to them later in the sequence do not alter any interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Regulator enable |
| uv_ok_i | input | 1 | Supply above the undervoltage threshold |
| vid_i | input | REF_W | Target voltage code from the processor, in 6.25 mV units |
| dly_sel_i | input | DLY_W | Delay interval code, in 0.25 ms units minus one |
| slew_sel_i | input | 3 | Ramp rate code |
| ref_code_o | output | REF_W | Reference code for the DAC |
| pwm_blank_o | output | 1 | Hold the PWM outputs off |
| pdet_win_o | output | 1 | Phase-detection window |
| pgood_o | output | 1 | Output voltage is good |

## Verification
Every result is due a known number of edges after the start edge. The phase window is due T edges after it, the boot code 8 + 176S edges after the window, and the captured-code edge one cycle plus T after that. Power-good is due at the closed formula in R8. The bench counts edges from the start edge and compares the edge count at which each output first changes against these formulas. It samples on the falling edge, so a design that is one cycle early or late is caught. It changes `vid_i`, the delay code and the slew code just before and just after the edges that capture them. This shows that only the captured values shape the timing and the final code. For an abort, the outputs are checked on the falling edge that follows the first rising edge that sees the dropped input.

// File: rtl/vrseq_pkg.sv
package vrseq_pkg;

    localparam int SLEW_W     = 3;
    localparam int SLEW_CODES = 1 << SLEW_W;
    localparam int DETECT_CYC = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DETECT,
        ST_RISE,
        ST_PARK,
        ST_SETTLE,
        ST_MASK,
        ST_BLANK,
        ST_READY
    } seq_state_e;

    // Controls from the sequencer to the reference datapath
    typedef struct packed {
        logic run;
        logic clear;
        logic use_target;
        logic load_target;
        logic capture;
    } ramp_ctl_t;

    // Output flags of the sequencer
    typedef struct packed {
        logic blank;
        logic detect;
        logic good;
    } seq_flags_t;

    // Ramp rate in mV per ms for each slew code
    function automatic int slew_rate_mv(input logic [SLEW_W-1:0] code);
        int r;
        case (code)
            3'd0, 3'd1: r = 300;
            3'd2:       r = 500;
            3'd3:       r = 700;
            3'd4:       r = 900;
            3'd5:       r = 1100;
            3'd6:       r = 1300;
            default:    r = 1500;
        endcase
        return r;
    endfunction

    // Clock cycles per 6.25 mV step: clk_khz * 6.25 / rate, at least one
    function automatic int step_period(input logic [SLEW_W-1:0] code, input int clk_khz);
        int p;
        p = (clk_khz * 25) / (4 * slew_rate_mv(code));
        if (p < 1) p = 1;
        return p;
    endfunction

    // Delay interval in cycles: (code + 1) units
    function automatic int interval_cycles(input int code, input int unit_cyc);
        return (code + 1) * unit_cyc;
    endfunction

endpackage

// File: rtl/vrseq_pacer.sv
module vrseq_pacer
    import vrseq_pkg::*;
#(
    parameter int CLK_KHZ = 100000,
    parameter int STEP_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  logic [SLEW_W-1:0] slew_i,
    input  logic              run_i,
    output logic              tick_o
);

    logic [STEP_W-1:0] period_tab [SLEW_CODES];
    logic [SLEW_W-1:0] slew_q;
    logic [STEP_W-1:0] cnt_q;

    // One constant reload value per slew code
    for (genvar g = 0; g < SLEW_CODES; g++) begin : g_period
        assign period_tab[g] = STEP_W'(step_period(SLEW_W'(g), CLK_KHZ) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slew_q <= 3'd2;
            cnt_q  <= '0;
        end else begin
            if (capture_i) slew_q <= slew_i;
            if (!run_i || cnt_q == '0) cnt_q <= period_tab[slew_q];
            else                       cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/vrseq_refgen.sv
module vrseq_refgen
    import vrseq_pkg::*;
#(
    parameter int REF_W     = 8,
    parameter int BOOT_CODE = 176
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic             use_target_i,
    input  logic             load_target_i,
    input  logic [REF_W-1:0] vid_i,
    output logic [REF_W-1:0] ref_o,
    output logic             at_goal_o
);

    localparam logic [REF_W-1:0] BOOT = REF_W'(BOOT_CODE);

    logic [REF_W-1:0] ref_q;
    logic [REF_W-1:0] tgt_q;
    logic [REF_W-1:0] goal;
    logic             upward;

    always_comb begin
        goal      = use_target_i ? tgt_q : BOOT;
        at_goal_o = (ref_q == goal);
        upward    = (goal > ref_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= '0;
            tgt_q <= '0;
        end else begin
            if (load_target_i) tgt_q <= vid_i;
            if (clear_i)
                ref_q <= '0;
            else if (tick_i && !at_goal_o)
                ref_q <= upward ? ref_q + 1'b1 : ref_q - 1'b1;
        end
    end

    assign ref_o = ref_q;

endmodule

// File: rtl/vrseq_ctrl.sv
module vrseq_ctrl
    import vrseq_pkg::*;
#(
    parameter int DLY_W    = 4,
    parameter int CNT_W    = 20,
    parameter int UNIT_CYC = 25000,
    parameter int MASK_CYC = 5000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             at_goal_i,
    output ramp_ctl_t        ctl_o,
    output seq_flags_t       flags_o
);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DLY_W-1:0] dly_q;
    logic             done;

    function automatic logic [CNT_W-1:0] td_m1(input logic [DLY_W-1:0] c);
        return CNT_W'(interval_cycles(int'(c), UNIT_CYC) - 1);
    endfunction

    assign done = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !go_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            if (rst) dly_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    state_q <= ST_WAIT;
                    cnt_q   <= td_m1(dly_i);
                    dly_q   <= dly_i;
                end
                ST_WAIT: begin
                    if (done) begin
                        state_q <= ST_DETECT;
                        cnt_q   <= CNT_W'(DETECT_CYC - 1);
                    end else cnt_q <= cnt_q - 1'b1;
                end
                ST_DETECT: begin
                    if (done) state_q <= ST_RISE;
                    else      cnt_q   <= cnt_q - 1'b1;
                end
                ST_RISE: begin
                    if (at_goal_i) begin
                        state_q <= ST_PARK;
                        cnt_q   <= td_m1(dly_q);
                    end
                end
                ST_PARK: begin
                    if (done) state_q <= ST_SETTLE;
                    else      cnt_q   <= cnt_q - 1'b1;
                end
                ST_SETTLE: begin
                    if (at_goal_i) begin
                        state_q <= ST_MASK;
                        cnt_q   <= CNT_W'(MASK_CYC - 1);
                    end
                end
                ST_MASK: begin
                    if (done) begin
                        state_q <= ST_BLANK;
                        cnt_q   <= td_m1(dly_q);
                    end else cnt_q <= cnt_q - 1'b1;
                end
                ST_BLANK: begin
                    if (done) state_q <= ST_READY;
                    else      cnt_q   <= cnt_q - 1'b1;
                end
                ST_READY: state_q <= ST_READY;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl_o.run         = (state_q == ST_RISE) || (state_q == ST_SETTLE);
        ctl_o.clear       = !go_i || (state_q == ST_IDLE);
        ctl_o.use_target  = (state_q == ST_SETTLE) || (state_q == ST_MASK) ||
                            (state_q == ST_BLANK)  || (state_q == ST_READY);
        ctl_o.load_target = (state_q == ST_PARK) && done;
        ctl_o.capture     = (state_q == ST_IDLE);
        flags_o.blank     = (state_q == ST_IDLE) || (state_q == ST_WAIT) ||
                            (state_q == ST_DETECT);
        flags_o.detect    = (state_q == ST_DETECT);
        flags_o.good      = (state_q == ST_READY);
    end

endmodule

// File: rtl/vrseq_top.sv
module vrseq_top
    import vrseq_pkg::*;
#(
    parameter int CLK_KHZ   = 100000,
    parameter int REF_W     = 8,
    parameter int DLY_W     = 4,
    parameter int BOOT_CODE = 176
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              uv_ok_i,
    input  logic [REF_W-1:0]  vid_i,
    input  logic [DLY_W-1:0]  dly_sel_i,
    input  logic [SLEW_W-1:0] slew_sel_i,
    output logic [REF_W-1:0]  ref_code_o,
    output logic              pwm_blank_o,
    output logic              pdet_win_o,
    output logic              pgood_o
);

    localparam int UNIT_CYC = CLK_KHZ / 4;
    localparam int MASK_CYC = (CLK_KHZ / 20 > 0) ? CLK_KHZ / 20 : 1;
    localparam int TD_MAX   = (1 << DLY_W) * UNIT_CYC;
    localparam int CNT_A    = (TD_MAX > MASK_CYC) ? TD_MAX : MASK_CYC;
    localparam int CNT_MAX  = (CNT_A > DETECT_CYC) ? CNT_A : DETECT_CYC;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int STEP_MAX = step_period(3'd0, CLK_KHZ);
    localparam int STEP_W   = $clog2(STEP_MAX + 1);

    logic       go;
    logic       tick;
    logic       at_goal;
    ramp_ctl_t  ctl;
    seq_flags_t flags;

    assign go = en_i && uv_ok_i;

    vrseq_ctrl #(
        .DLY_W    (DLY_W),
        .CNT_W    (CNT_W),
        .UNIT_CYC (UNIT_CYC),
        .MASK_CYC (MASK_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .go_i      (go),
        .dly_i     (dly_sel_i),
        .at_goal_i (at_goal),
        .ctl_o     (ctl),
        .flags_o   (flags)
    );

    vrseq_pacer #(
        .CLK_KHZ (CLK_KHZ),
        .STEP_W  (STEP_W)
    ) u_pacer (
        .clk       (clk),
        .rst       (rst),
        .capture_i (ctl.capture),
        .slew_i    (slew_sel_i),
        .run_i     (ctl.run),
        .tick_o    (tick)
    );

    vrseq_refgen #(
        .REF_W     (REF_W),
        .BOOT_CODE (BOOT_CODE)
    ) u_ref (
        .clk           (clk),
        .rst           (rst),
        .clear_i       (ctl.clear),
        .tick_i        (tick),
        .use_target_i  (ctl.use_target),
        .load_target_i (ctl.load_target),
        .vid_i         (vid_i),
        .ref_o         (ref_code_o),
        .at_goal_o     (at_goal)
    );

    assign pwm_blank_o = flags.blank;
    assign pdet_win_o  = flags.detect;
    assign pgood_o     = flags.good;

endmodule

// File: rtl/vrseq_sva.sv
module vrseq_sva #(
    parameter int REF_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en_i,
    input logic             uv_ok_i,
    input logic [REF_W-1:0] ref_code_i,
    input logic             pwm_blank_i,
    input logic             pdet_win_i,
    input logic             pgood_i
);

    localparam logic [REF_W-1:0] ONE = REF_W'(1);

    // R4 and R6: the reference moves by at most one code per cycle, except when it is cleared
    p_ref_single_step_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(ref_code_i) |->
            (ref_code_i == $past(ref_code_i) + ONE) ||
            (ref_code_i == $past(ref_code_i) - ONE) ||
            (ref_code_i == '0));

    // R9: a dropped input forces the idle outputs after the next edge
    p_abort_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !(en_i && uv_ok_i) |=>
            (ref_code_i == '0) && pwm_blank_i && !pgood_i && !pdet_win_i);

    // R3: the detection window is blanked and the reference is still zero
    p_detect_blanked_r3: assert property (@(posedge clk) disable iff (rst)
        pdet_win_i |-> (pwm_blank_i && ref_code_i == '0));

    // R1: the window appears only after both inputs were seen high
    p_detect_needs_go_r1: assert property (@(posedge clk) disable iff (rst)
        pdet_win_i |-> $past(en_i && uv_ok_i));

    // R8: power-good implies the PWM outputs run and stays while qualified
    p_good_unblanked_r8: assert property (@(posedge clk) disable iff (rst)
        pgood_i |-> (!pwm_blank_i && !pdet_win_i));

    p_good_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (pgood_i && en_i && uv_ok_i) |=> pgood_i);

endmodule

bind vrseq_top vrseq_sva #(.REF_W(REF_W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .uv_ok_i     (uv_ok_i),
    .ref_code_i  (ref_code_o),
    .pwm_blank_i (pwm_blank_o),
    .pdet_win_i  (pdet_win_o),
    .pgood_i     (pgood_o)
);

// File: tb/vrseq_top_tb_top.sv
module vrseq_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_KHZ    = 400;
    localparam int REF_W      = 8;
    localparam int DLY_W      = 4;
    localparam int BOOT       = 176;
    localparam int UNIT       = CLK_KHZ / 4;
    localparam int MASKC      = CLK_KHZ / 20;
    localparam int WDOG       = 150000;

    typedef struct packed {
        logic [2:0]       slew;
        logic [DLY_W-1:0] dly;
        logic [REF_W-1:0] vid;
        logic [REF_W-1:0] decoy;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 4'd0, 8'd200, 8'd20},
        '{3'd1, 4'd1, 8'd100, 8'd230},
        '{3'd2, 4'd0, 8'd176, 8'd60},
        '{3'd3, 4'd2, 8'd255, 8'd0},
        '{3'd4, 4'd0, 8'd0,   8'd250},
        '{3'd5, 4'd1, 8'd177, 8'd90},
        '{3'd6, 4'd0, 8'd175, 8'd3},
        '{3'd7, 4'd3, 8'd150, 8'd200}
    };

    logic             clk;
    logic             rst;
    logic             en;
    logic             uv;
    logic [REF_W-1:0] vid;
    logic [DLY_W-1:0] dly;
    logic [2:0]       slew;
    logic [REF_W-1:0] ref_code;
    logic             pwm_blank;
    logic             pdet_win;
    logic             pgood;

    int checks = 0;
    int fails  = 0;

    vrseq_top #(
        .CLK_KHZ   (CLK_KHZ),
        .REF_W     (REF_W),
        .DLY_W     (DLY_W),
        .BOOT_CODE (BOOT)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en),
        .uv_ok_i     (uv),
        .vid_i       (vid),
        .dly_sel_i   (dly),
        .slew_sel_i  (slew),
        .ref_code_o  (ref_code),
        .pwm_blank_o (pwm_blank),
        .pdet_win_o  (pdet_win),
        .pgood_o     (pgood)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Step period from the rate table of R7
    function automatic int exp_step(input int code);
        int rate;
        int p;
        case (code)
            0, 1:    rate = 300;
            2:       rate = 500;
            3:       rate = 700;
            4:       rate = 900;
            5:       rate = 1100;
            6:       rate = 1300;
            default: rate = 1500;
        endcase
        p = (CLK_KHZ * 625) / (rate * 100);
        return (p < 1) ? 1 : p;
    endfunction

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v);
        int s, td, d, n, first_pdet, pdet_cnt, pdet_ref_bad, unblank, boot_n, good_n;
        int exp_pdet, exp_unblank, exp_boot, exp_park, exp_good;
        @(negedge clk);
        en = 1'b0;
        uv = 1'b0;
        cycle();
        slew = v.slew;
        dly  = v.dly;
        vid  = v.decoy;
        en   = 1'b1;
        uv   = 1'b1;
        s  = exp_step(int'(v.slew));
        td = (int'(v.dly) + 1) * UNIT;
        d  = (int'(v.vid) > BOOT) ? int'(v.vid) - BOOT : BOOT - int'(v.vid);
        exp_pdet    = td + 1;
        exp_unblank = td + 9;
        exp_boot    = td + 9 + 176 * s;
        exp_park    = 2 * td + 10 + 176 * s;
        exp_good    = 3 * td + 11 + 176 * s + d * s + MASKC;
        n = 0; first_pdet = 0; pdet_cnt = 0; pdet_ref_bad = 0;
        unblank = 0; boot_n = 0; good_n = 0;
        while (good_n == 0 && n < 20000) begin
            cycle();
            n++;
            // R10: change the delay and slew codes after the start edge
            if (n == 2) begin
                slew = ~v.slew;
                dly  = ~v.dly;
            end
            if (pdet_win) begin
                pdet_cnt++;
                if (first_pdet == 0) first_pdet = n;
                if (ref_code != '0) pdet_ref_bad++;
            end
            if (!pwm_blank && unblank == 0) unblank = n;
            if (int'(ref_code) == BOOT && boot_n == 0) boot_n = n;
            // R5: real target shown during the hold, garbage right after the capture edge
            if (n == exp_boot) vid = v.vid;
            if (n == exp_park) vid = ~v.vid;
            if (pgood) good_n = n;
        end
        check_eq("R2 first detect-window cycle", first_pdet, exp_pdet);
        check_eq("R3 detect-window length", pdet_cnt, 8);
        check_eq("R3 reference nonzero in window", pdet_ref_bad, 0);
        check_eq("R3 blank release cycle", unblank, exp_unblank);
        check_eq("R4 R7 boot code reached", boot_n, exp_boot);
        check_eq("R8 R10 power-good cycle", good_n, exp_good);
        check_eq("R5 R6 final reference code", int'(ref_code), int'(v.vid));
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        int bad;
        int waited;
        rst  = 1'b1;
        en   = 1'b1;
        uv   = 1'b1;
        vid  = 8'd200;
        dly  = '0;
        slew = 3'd7;
        repeat (5) cycle();
        // Reset state
        check_eq("R1 reset reference", int'(ref_code), 0);
        check_eq("R1 reset blank", int'(pwm_blank), 1);
        check_eq("R1 reset power-good", int'(pgood), 0);
        rst = 1'b0;
        en  = 1'b0;
        uv  = 1'b0;
        cycle();

        // R1: one qualifying input alone never starts the sequence
        bad = 0;
        en = 1'b1; uv = 1'b0;
        for (int i = 0; i < 300; i++) begin
            cycle();
            if (pdet_win || !pwm_blank || ref_code != '0 || pgood) bad++;
        end
        check_eq("R1 enable without supply-good", bad, 0);
        bad = 0;
        en = 1'b0; uv = 1'b1;
        for (int i = 0; i < 300; i++) begin
            cycle();
            if (pdet_win || !pwm_blank || ref_code != '0 || pgood) bad++;
        end
        check_eq("R1 supply-good without enable", bad, 0);

        // Table walk
        for (int k = 0; k < 8; k++) run_vec(VECS[k]);

        // R8: power-good persists while qualified
        repeat (50) cycle();
        check_eq("R8 power-good held", int'(pgood), 1);

        // R9: abort during the boot ramp
        en = 1'b0; uv = 1'b0;
        cycle();
        slew = 3'd7; dly = '0; vid = 8'd120;
        en = 1'b1; uv = 1'b1;
        waited = 0;
        while (int'(ref_code) < 20 && waited < 5000) begin
            cycle();
            waited++;
        end
        uv = 1'b0;
        cycle();
        check_eq("R9 abort clears reference", int'(ref_code), 0);
        check_eq("R9 abort blanks PWM", int'(pwm_blank), 1);
        check_eq("R9 abort window off", int'(pdet_win), 0);

        // R9: abort after power-good
        uv = 1'b1;
        waited = 0;
        while (!pgood && waited < 5000) begin
            cycle();
            waited++;
        end
        check_eq("R8 restart reaches power-good", int'(pgood), 1);
        check_eq("R6 restart final code", int'(ref_code), 120);
        en = 1'b0;
        cycle();
        check_eq("R9 drop clears power-good", int'(pgood), 0);
        check_eq("R9 drop clears reference", int'(ref_code), 0);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule